// File: doc/BRIEF.md
# Dual-Mode Digital Phase Comparator

This block compares a reference square wave with a feedback square wave from a loop oscillator. Both inputs are asynchronous. A fast system clock oversamples them through a synchronizer chain of configurable depth. Two detectors watch the same pair of conditioned inputs.

The first detector is a plain exclusive-OR. With 50% duty inputs, its average output steers a loop so that it settles at a quarter-period offset. With no reference present, that average sits at mid-scale. The second detector is a three-state machine that reacts only to rising edges. It asks for "raise" while the reference leads and "lower" while the feedback leads, and it rests idle when the edges coincide. It therefore settles at zero phase and cannot lock on a harmonic. When the reference is missing, the feedback edges alone keep it asking for "lower", which pushes the oscillator to its lowest frequency.

A mode input selects which detector drives the shared two-bit error port. The outputs of both detectors are also visible on their own ports. A lock indicator shows when the edge detector is requesting no correction.

Top module: `dual_phase_comparator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge detector goes idle after that edge: `pfd_up`=0, `pfd_dn`=0, `pfd_err`=2'b00, `lock_pulse`=1. The synchronizer chains also clear to 0.
- R2: `xor_err` equals the exclusive-OR of `ref_in` and `fb_in` as sampled SYNC_STAGES clock edges earlier.
- R3: A rising edge on the conditioned reference with no feedback edge in the same cycle moves the detector one step toward "up": down goes to idle, and idle goes to up. Up stays up.
- R4: A rising edge on the conditioned feedback with no reference edge in the same cycle moves the detector one step toward "down": up goes to idle, and idle goes to down. Down stays down.
- R5: Reference and feedback rising edges in the same cycle leave the detector state unchanged.
- R6: Input levels, falling edges and steady highs have no effect on the detector state. Only rising edges change it.
- R7: `pfd_err` is 2'b10 in the up state, 2'b01 in the down state and 2'b00 when idle. `pfd_up` and `pfd_dn` are never high together.
- R8: `lock_pulse` is high exactly when the edge detector is idle.
- R9: `err_out` equals `pfd_err` when `mode_sel`=1. When `mode_sel`=0, it is 2'b10 if `xor_err`=1 and 2'b01 if `xor_err`=0.
- R10: With the reference held still and the feedback toggling, the detector reaches down and stays there, so `pfd_err` remains 2'b01.
- R11: A state change takes effect on the clock edge SYNC_STAGES+1 edges after the edge that first samples the new input level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples both inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal from the oscillator, asynchronous |
| mode_sel | input | 1 | 0: XOR detector drives `err_out`; 1: edge detector drives it |
| err_out | output | 2 | Shared error code: 2'b10 drive high, 2'b01 drive low, 2'b00 float |
| xor_err | output | 1 | XOR detector output |
| pfd_up | output | 1 | Edge detector requests a higher frequency |
| pfd_dn | output | 1 | Edge detector requests a lower frequency |
| pfd_err | output | 2 | Edge detector error code |
| lock_pulse | output | 1 | High while the edge detector requests no correction |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. A latency error of one stage therefore shows up as a mismatch against the queue-based reference model. The deeper chain also widens the gap between sampling and the state update, so R11 is exercised beyond the trivial depth.

The stimulus includes:
- reference-only and feedback-only pulse trains, which drive the detector through both one-step returns to idle;
- coincident edges;
- a long reference high level;
- free-running squares of unequal period;
- a random stretch in which the mode input toggles.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'b00,
    PS_UP   = 2'b01,
    PS_DN   = 2'b10
  } pfd_state_t;

  localparam logic [1:0] DRV_HI = 2'b10;
  localparam logic [1:0] DRV_LO = 2'b01;
  localparam logic [1:0] DRV_Z  = 2'b00;

  // One step of the edge-driven state machine.
  function automatic pfd_state_t pfd_step(pfd_state_t cur, logic r_edge, logic f_edge);
    pfd_state_t nxt;
    nxt = cur;
    if (r_edge && !f_edge) begin
      nxt = (cur == PS_DN) ? PS_IDLE : PS_UP;
    end else if (f_edge && !r_edge) begin
      nxt = (cur == PS_UP) ? PS_IDLE : PS_DN;
    end
    return nxt;
  endfunction

  // Error code driven for a given state.
  function automatic logic [1:0] pfd_code(pfd_state_t cur);
    logic [1:0] c;
    case (cur)
      PS_UP:   c = DRV_HI;
      PS_DN:   c = DRV_LO;
      default: c = DRV_Z;
    endcase
    return c;
  endfunction

  // XOR detector maps to a two-level drive.
  function automatic logic [1:0] xor_code(logic x);
    return x ? DRV_HI : DRV_LO;
  endfunction

endpackage

// File: rtl/dpc_edge_sense.sv
module dpc_edge_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/dpc_pfd.sv
module dpc_pfd
  import dpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_rise,
  input  logic       fb_rise,
  output logic       up,
  output logic       dn,
  output logic [1:0] err,
  output logic       lock
);
  pfd_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_IDLE;
    else        state <= pfd_step(state, ref_rise, fb_rise);
  end

  assign up   = (state == PS_UP);
  assign dn   = (state == PS_DN);
  assign err  = pfd_code(state);
  assign lock = (state == PS_IDLE);
endmodule

// File: rtl/dual_phase_comparator.sv
module dual_phase_comparator
  import dpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic       fb_in,
  input  logic       mode_sel,
  output logic [1:0] err_out,
  output logic       xor_err,
  output logic       pfd_up,
  output logic       pfd_dn,
  output logic [1:0] pfd_err,
  output logic       lock_pulse
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] lvl;
  logic [NUM_IN-1:0] rise;
  logic              ref_rise;
  logic              fb_rise;

  assign raw_in = {fb_in, ref_in};

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_cond
      dpc_edge_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in[gi]),
        .level (lvl[gi]),
        .rise  (rise[gi])
      );
    end
  endgenerate

  assign ref_rise = rise[0];
  assign fb_rise  = rise[1];

  assign xor_err = lvl[0] ^ lvl[1];

  dpc_pfd u_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .up       (pfd_up),
    .dn       (pfd_dn),
    .err      (pfd_err),
    .lock     (lock_pulse)
  );

  assign err_out = mode_sel ? pfd_err : xor_code(xor_err);
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_sel,
  input logic       ref_rise,
  input logic       fb_rise,
  input logic       pfd_up,
  input logic       pfd_dn,
  input logic [1:0] pfd_err,
  input logic [1:0] err_out,
  input logic       lock_pulse
);
  // R7
  up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pfd_up && pfd_dn));

  // R8
  lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse == (!pfd_up && !pfd_dn));

  // R3
  ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && !pfd_dn) |=> pfd_up);

  // R4
  fb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && !pfd_up) |=> pfd_dn);

  // R5
  coincident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> $stable(pfd_err));

  // R6
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_rise && !fb_rise) |=> $stable(pfd_err));

  // R9
  mode_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |-> (err_out == pfd_err));

  // R9
  xor_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel |-> $countones(err_out) == 1);
endmodule

bind dual_phase_comparator dpc_checker u_dpc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sel   (mode_sel),
  .ref_rise   (ref_rise),
  .fb_rise    (fb_rise),
  .pfd_up     (pfd_up),
  .pfd_dn     (pfd_dn),
  .pfd_err    (pfd_err),
  .err_out    (err_out),
  .lock_pulse (lock_pulse)
);

// File: tb/test_dual_phase_comparator.sv
module test_dual_phase_comparator;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       fb_in = 1'b0;
  logic       mode_sel = 1'b0;
  logic [1:0] err_out;
  logic       xor_err;
  logic       pfd_up;
  logic       pfd_dn;
  logic [1:0] pfd_err;
  logic       lock_pulse;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  dual_phase_comparator #(.SYNC_STAGES(SYNC)) i_dual_phase_comparator (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_in     (ref_in),
    .fb_in      (fb_in),
    .mode_sel   (mode_sel),
    .err_out    (err_out),
    .xor_err    (xor_err),
    .pfd_up     (pfd_up),
    .pfd_dn     (pfd_dn),
    .pfd_err    (pfd_err),
    .lock_pulse (lock_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model: delay lines as queues, state as an integer
  // (0 rest, 1 raise, 2 lower).
  bit q_ref[$];
  bit q_fb[$];
  bit m_ref = 0, m_fb = 0, m_ref_old = 0, m_fb_old = 0;
  int m_st = 0;

  function automatic void model_clear();
    q_ref.delete(); q_fb.delete();
    for (int k = 0; k < SYNC - 1; k++) begin
      q_ref.push_back(1'b0); q_fb.push_back(1'b0);
    end
    m_ref = 0; m_fb = 0; m_ref_old = 0; m_fb_old = 0; m_st = 0;
  endfunction

  function automatic void model_step();
    bit er, ef;
    if (!rst_n) begin
      model_clear();
      return;
    end
    er = m_ref && !m_ref_old;
    ef = m_fb && !m_fb_old;
    if (er && !ef)      m_st = (m_st == 2) ? 0 : 1;
    else if (ef && !er) m_st = (m_st == 1) ? 0 : 2;
    m_ref_old = m_ref;
    m_fb_old  = m_fb;
    q_ref.push_back(ref_in); q_fb.push_back(fb_in);
    m_ref = q_ref.pop_front();
    m_fb  = q_fb.pop_front();
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_err, e_out;
    e_err = (m_st == 1) ? 2 : (m_st == 2) ? 1 : 0;
    e_out = mode_sel ? e_err : ((m_ref ^ m_fb) ? 2 : 1);
    chk("R2", "xor_err", xor_err, m_ref ^ m_fb);
    chk("R3", "pfd_up", pfd_up, m_st == 1);
    chk("R4", "pfd_dn", pfd_dn, m_st == 2);
    chk("R7", "pfd_err", pfd_err, e_err);
    chk("R8", "lock_pulse", lock_pulse, m_st == 0);
    chk("R9", "err_out", err_out, e_out);
  endtask

  // One clock: update model at edge, compare a quarter period later.
  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      #(CLK_PERIOD/4);
      compare_all();
    end
  endtask

  initial begin
    model_clear();
    tick(3);
    // R1: reset state
    chk("R1", "reset lock", lock_pulse, 1);
    chk("R1", "reset pfd_err", pfd_err, 0);
    chk("R1", "reset xor", xor_err, 0);
    rst_n = 1'b1;
    mode_sel = 1'b1;
    tick(2);

    // R11: reference rise, state changes SYNC+1 edges after first sample
    ref_in = 1'b1;
    tick(SYNC);
    chk("R11", "no change yet", pfd_up, 0);
    tick(1);
    chk("R11", "raise after latency", pfd_up, 1);
    // R6: hold reference high, no further effect
    tick(20);
    chk("R6", "level holds raise", pfd_err, 2);
    ref_in = 1'b0;
    tick(10);
    chk("R6", "fall has no effect", pfd_err, 2);
    // R4: feedback edge returns raise to rest
    fb_in = 1'b1;
    tick(SYNC + 1);
    chk("R4", "raise to rest", lock_pulse, 1);
    fb_in = 1'b0;
    tick(4);

    // R10: no reference, feedback toggles -> lower and stays
    for (int p = 0; p < 8; p++) begin
      fb_in = ~fb_in;
      tick(5);
    end
    chk("R10", "stays lower", pfd_err, 1);
    // R3: reference edge returns lower to rest
    ref_in = 1'b1;
    tick(SYNC + 1);
    chk("R3", "lower to rest", lock_pulse, 1);
    ref_in = 1'b0; fb_in = 1'b0;
    tick(4);

    // R5: coincident edges keep rest
    for (int p = 0; p < 6; p++) begin
      ref_in = 1'b1; fb_in = 1'b1;
      tick(4);
      ref_in = 1'b0; fb_in = 1'b0;
      tick(4);
    end
    chk("R5", "coincident rest", pfd_err, 0);

    // R2 / R9: squares of unequal period, both modes
    for (int c = 0; c < 400; c++) begin
      ref_in = (c % 14) < 7;
      fb_in  = (c % 18) < 9;
      if (c == 200) mode_sel = 1'b0;
      tick(1);
    end

    // Random stretch with mode toggling and mid-run reset
    for (int c = 0; c < 3000; c++) begin
      ref_in = $urandom_range(0, 1);
      fb_in  = $urandom_range(0, 1);
      if ((c % 37) == 0) mode_sel = ~mode_sel;
      rst_n = (c != 1500);
      tick(1);
    end
    rst_n = 1'b1;
    tick(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule